// File: doc/BRIEF.md
# Multiplexed Bus Port-Size Lane Steering

This block turns one internal 32-bit read or write request into one or more cycles on an external 32-bit bus. That bus carries both address and data on the same wires. Every beat opens with a single address clock, in which the whole beat address is driven on all 32 bits. A data phase follows and lasts until the external side raises `bus_ready`.

The request carries a port size (8, 16 or 32 bits) and a lane-shift flag. Together these decide which byte lanes carry data in the data phase. Lanes that do not carry data keep driving the matching bits of the beat address.

A 32-bit transfer to an 8-bit port is split into four byte beats. A 32-bit transfer to a 16-bit port is split into two halfword beats. The beat address steps by the port width on each beat. On reads, the bytes returned on each beat are placed into a holding word, and a one-cycle `done` pulse reports the finished transfer.

Top module: `mux_bus_lane_steer`

## Requirements
- R1: A request (`req_valid` high at a clock edge) is accepted only while `busy` is low. A `req_valid` seen while a transfer is in progress starts no bus beat and does not change the transfer already running.
- R2: Each beat starts with exactly one clock in which `bus_start` is 1, `bus_ad_out` equals the full 32-bit beat address, `bus_lane_oe` is 4'b1111 and `bus_be` is 4'b0000. The data phase follows in the next clock.
- R3: Port size code 2'b00 (32-bit) makes one data beat. In that beat `bus_be` is 4'b1111 and a write drives the whole write word on `bus_ad_out`.
- R4: With `req_shift`=0, an 8-bit port carries data on bits 31:24 (`bus_be`=4'b1000), and a 16-bit port carries data on bits 31:16 (`bus_be`=4'b1100). Bit i of `bus_be` and of `bus_lane_oe` stands for bits 8i+7:8i.
- R5: With `req_shift`=1, an 8-bit port carries data on bits 7:0 (`bus_be`=4'b0001), and a 16-bit port carries data on bits 15:0 (`bus_be`=4'b0011).
- R6: During a data phase, every lane whose `bus_be` bit is 0 drives the matching bits of the current beat address. On a write, all lanes are enabled. On a read, `bus_lane_oe` is the complement of `bus_be`.
- R7: Port code 2'b01 (8-bit) makes four beats carrying bytes 0, 1, 2 and 3 in that order, where byte k is bits 8k+7:8k of the word. The beat address is the request address plus k.
- R8: Port codes 2'b10 and 2'b11 (16-bit) make two beats. The first carries bits 15:0 of the word at the request address, and the second carries bits 31:16 at the request address plus 2.
- R9: A data phase, with its `bus_ad_out`, `bus_be` and `bus_lane_oe`, holds unchanged until `bus_ready` is 1 at a clock edge.
- R10: On a read, the data lanes of `bus_rd_in` are captured on each ready beat into the byte positions given in R7/R8, and `rdata` holds the assembled word. `done` is high for exactly one clock, the clock after the final beat's ready.
- R11: In the clock after the final beat's ready, `busy`, `bus_start`, `bus_be` and `bus_lane_oe` are all 0.
- R12: After reset `busy`, `done`, `bus_start`, `bus_be`, `bus_lane_oe` and `bus_ad_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Write word |
| req_port | input | 2 | Port size: 00 = 32-bit, 01 = 8-bit, 10/11 = 16-bit |
| req_shift | input | 1 | Move narrow-port data to the low lanes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock pulse after the final beat |
| rdata | output | 32 | Assembled read word, valid with done |
| bus_ad_out | output | 32 | Multiplexed address/data drive value |
| bus_lane_oe | output | 4 | Per-lane drive enable |
| bus_start | output | 1 | Address clock of a beat |
| bus_be | output | 4 | Per-lane byte enable in the data phase |
| bus_rnw | output | 1 | 1 = read or idle, 0 = write |
| bus_rd_in | input | 32 | Data returned by the external side |
| bus_ready | input | 1 | Ends the current data phase |

## Verification
The assertions assume that `bus_ready` is only relevant during a data phase, and that the external side returns valid bytes on the enabled lanes in the clock where it raises ready. The bench's responder raises ready only while `bus_be` is nonzero, after a programmed number of wait clocks, and it places the expected bytes on exactly the enabled lanes. The other lanes are filled with a fixed filler pattern, so a wrong lane pick shows up in `rdata`. Requests are driven while idle, except in one deliberate case where `req_valid` is held high with a different address during a transfer.

// File: rtl/mux_bus_lane_steer.sv
module mux_bus_lane_steer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [1:0]  req_port,
  input  logic        req_shift,
  output logic        busy,
  output logic        done,
  output logic [31:0] rdata,
  output logic [31:0] bus_ad_out,
  output logic [3:0]  bus_lane_oe,
  output logic        bus_start,
  output logic [3:0]  bus_be,
  output logic        bus_rnw,
  input  logic [31:0] bus_rd_in,
  input  logic        bus_ready
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} st_t;

  st_t         st;
  logic        wr_q, shift_q, done_q;
  logic [1:0]  port_q, beat_q;
  logic [31:0] addr_q, wdata_q, hold_q;

  wire is32 = (port_q == 2'b00);
  wire is8  = (port_q == 2'b01);
  wire is16 = port_q[1];

  wire last_beat = is32 | (is16 & beat_q[0]) | (is8 & (beat_q == 2'd3));

  logic [1:0] off;
  always_comb begin
    if (is8)       off = beat_q;
    else if (is16) off = {beat_q[0], 1'b0};
    else           off = 2'd0;
  end
  wire [31:0] beat_addr = addr_q + {30'd0, off};

  logic [3:0] lane_m;
  always_comb begin
    if (is32)     lane_m = 4'b1111;
    else if (is8) lane_m = shift_q ? 4'b0001 : 4'b1000;
    else          lane_m = shift_q ? 4'b0011 : 4'b1100;
  end
  wire [31:0] lane_bits = {{8{lane_m[3]}}, {8{lane_m[2]}}, {8{lane_m[1]}}, {8{lane_m[0]}}};

  wire [7:0]  byte_sel = wdata_q[{beat_q, 3'b000} +: 8];
  wire [15:0] half_sel = wdata_q[{beat_q[0], 4'b0000} +: 16];
  wire [31:0] place = is32 ? wdata_q : (is8 ? {4{byte_sel}} : {2{half_sel}});

  wire [31:0] data_drive = wr_q ? ((place & lane_bits) | (beat_addr & ~lane_bits)) : beat_addr;

  wire [7:0]  rx_byte = shift_q ? bus_rd_in[7:0]  : bus_rd_in[31:24];
  wire [15:0] rx_half = shift_q ? bus_rd_in[15:0] : bus_rd_in[31:16];

  assign busy        = (st != S_IDLE);
  assign done        = done_q;
  assign rdata       = hold_q;
  assign bus_start   = (st == S_ADDR);
  assign bus_be      = (st == S_DATA) ? lane_m : 4'b0000;
  assign bus_rnw     = (st == S_IDLE) | ~wr_q;
  assign bus_ad_out  = (st == S_ADDR) ? beat_addr : ((st == S_DATA) ? data_drive : 32'd0);
  assign bus_lane_oe = (st == S_ADDR) ? 4'b1111 :
                       ((st == S_DATA) ? (wr_q ? 4'b1111 : ~lane_m) : 4'b0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      wr_q    <= 1'b0;
      shift_q <= 1'b0;
      done_q  <= 1'b0;
      port_q  <= 2'b00;
      beat_q  <= 2'd0;
      addr_q  <= 32'd0;
      wdata_q <= 32'd0;
      hold_q  <= 32'd0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          wr_q    <= req_write;
          shift_q <= req_shift;
          port_q  <= req_port;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          beat_q  <= 2'd0;
          hold_q  <= 32'd0;
          st      <= S_ADDR;
        end
        S_ADDR: st <= S_DATA;
        S_DATA: if (bus_ready) begin
          if (!wr_q) begin
            if (is32)     hold_q <= bus_rd_in;
            else if (is8) hold_q[{beat_q, 3'b000} +: 8] <= rx_byte;
            else          hold_q[{beat_q[0], 4'b0000} +: 16] <= rx_half;
          end
          if (last_beat) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            beat_q <= beat_q + 2'd1;
            st     <= S_ADDR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_addr_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |-> (bus_be == 4'b0000) && (bus_lane_oe == 4'b1111));

  assert_start_then_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !bus_start && (bus_be != 4'b0000));

  assert_lane_pattern_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_be != 4'b0000) |-> ((bus_be == 4'b1111) || (bus_be == 4'b1000) || (bus_be == 4'b1100) ||
                             (bus_be == 4'b0001) || (bus_be == 4'b0011)));

  assert_read_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_be != 4'b0000) && bus_rnw) |-> ((bus_lane_oe & bus_be) == 4'b0000) &&
                                         ((bus_lane_oe | bus_be) == 4'b1111));

  assert_hold_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_be != 4'b0000) && !bus_ready) |=> $stable(bus_be) && $stable(bus_ad_out) && $stable(bus_lane_oe));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_after_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !bus_start && (bus_be == 4'b0000) && (bus_lane_oe == 4'b0000));

  assert_no_start_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !bus_start);

endmodule

// File: tb/mux_bus_lane_steer_tb.sv
module mux_bus_lane_steer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_shift = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_port = 2'b00;
  logic        busy, done, bus_start, bus_rnw;
  logic [31:0] rdata, bus_ad_out;
  logic [3:0]  bus_lane_oe, bus_be;
  logic [31:0] bus_rd_in = '0;
  logic        bus_ready = 1'b0;

  always #4 clk = ~clk;

  mux_bus_lane_steer u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_port(req_port), .req_shift(req_shift),
    .busy(busy), .done(done), .rdata(rdata), .bus_ad_out(bus_ad_out),
    .bus_lane_oe(bus_lane_oe), .bus_start(bus_start), .bus_be(bus_be), .bus_rnw(bus_rnw),
    .bus_rd_in(bus_rd_in), .bus_ready(bus_ready)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] ad;
    logic [31:0] rd;
    logic [3:0]  be;
    logic [3:0]  oe;
    logic        rnw;
  } beat_t;

  beat_t q[$];
  int    errors = 0;
  int    checks = 0;
  int    waits_g = 0;
  int    wcnt = 0;
  bit    ready_drv = 1'b0;
  bit    finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expand(input logic [3:0] m);
    return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
  endfunction

  // monitor and responder: pops expected beats as the bus consumes them
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (ready_drv) begin
        if (q.size() > 0) void'(q.pop_front());
        ready_drv = 1'b0;
        bus_ready = 1'b0;
      end
      if (bus_start) begin
        wcnt = 0;
        if (q.size() == 0) chk(1'b0, "R1 unexpected beat", bus_ad_out, 32'd0);
        else begin
          chk(bus_ad_out == q[0].addr, "R2 address clock", bus_ad_out, q[0].addr);
          chk(bus_be == 4'b0000 && bus_lane_oe == 4'b1111, "R2 addr enables",
              {24'd0, bus_be, bus_lane_oe}, 32'h0000000F);
        end
      end else if (bus_be != 4'b0000 && q.size() > 0) begin
        logic [31:0] om;
        om = expand(q[0].oe);
        chk(bus_be == q[0].be, "R4/R5 byte enables", {28'd0, bus_be}, {28'd0, q[0].be});
        chk(bus_lane_oe == q[0].oe, "R6 lane drive", {28'd0, bus_lane_oe}, {28'd0, q[0].oe});
        chk((bus_ad_out & om) == (q[0].ad & om), "R6/R7/R8 data phase lanes", bus_ad_out & om, q[0].ad & om);
        chk(bus_rnw == q[0].rnw, "R9 direction", {31'd0, bus_rnw}, {31'd0, q[0].rnw});
        if (wcnt >= waits_g) begin
          bus_ready = 1'b1;
          bus_rd_in = q[0].rd;
          ready_drv = 1'b1;
        end else wcnt++;
      end
    end
  end

  task automatic xfer(input bit wr, input logic [31:0] a, input logic [31:0] d,
                      input logic [1:0] p, input bit sh, input int waits, input bit poke);
    int nb, step;
    logic [3:0] m;
    logic [31:0] lb;
    nb   = (p == 2'b00) ? 1 : ((p == 2'b01) ? 4 : 2);
    step = (p == 2'b00) ? 0 : ((p == 2'b01) ? 1 : 2);
    m    = (p == 2'b00) ? 4'b1111 : ((p == 2'b01) ? (sh ? 4'b0001 : 4'b1000) : (sh ? 4'b0011 : 4'b1100));
    lb   = expand(m);
    for (int k = 0; k < nb; k++) begin
      beat_t b;
      logic [31:0] ba, rep;
      ba = a + step * k;
      if (p == 2'b00)      rep = d;
      else if (p == 2'b01) rep = {4{d[8*k +: 8]}};
      else                 rep = {2{d[16*k +: 16]}};
      b.addr = ba;
      b.ad   = wr ? ((rep & lb) | (ba & ~lb)) : ba;
      b.rd   = (rep & lb) | (32'hA5C3_5A3C & ~lb);
      b.be   = m;
      b.oe   = wr ? 4'b1111 : ~m;
      b.rnw  = ~wr;
      q.push_back(b);
    end
    waits_g = waits;
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_port = p; req_shift = sh;
    @(negedge clk); #1;
    if (poke) begin
      req_addr = a ^ 32'h0000_1000; req_wdata = ~d; req_write = ~wr;
    end else req_valid = 1'b0;
    while (!done) begin @(negedge clk); #1; end
    req_valid = 1'b0;
    if (!wr) chk(rdata == d, "R10 read assembly", rdata, d);
    chk(!busy && !bus_start && bus_be == 4'b0000 && bus_lane_oe == 4'b0000, "R11 idle after last ready",
        {24'd0, bus_be, bus_lane_oe} | {31'd0, busy}, 32'd0);
    @(negedge clk); #1;
    chk(!done, "R10 done single pulse", {31'd0, done}, 32'd0);
    chk(q.size() == 0, "R7/R8 beat count", q.size(), 32'd0);
    q.delete();
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_start && bus_be == 4'b0000 && bus_lane_oe == 4'b0000 && bus_ad_out == 32'd0,
        "R12 reset state", bus_ad_out | {28'd0, bus_be}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    xfer(1'b1, 32'h1000_0040, 32'hDEAD_BEEF, 2'b00, 1'b0, 0, 1'b0); // R3
    xfer(1'b1, 32'h2000_0100, 32'h4433_2211, 2'b01, 1'b0, 1, 1'b0); // R4 R7
    xfer(1'b1, 32'h3000_0200, 32'hCAFE_F00D, 2'b10, 1'b0, 0, 1'b0); // R4 R8
    xfer(1'b1, 32'h4000_0301, 32'h8877_6655, 2'b01, 1'b1, 0, 1'b0); // R5 R7
    xfer(1'b1, 32'h5000_0402, 32'h1357_9BDF, 2'b11, 1'b1, 2, 1'b0); // R5 R8 code 11
    xfer(1'b1, 32'h0000_FFFF, 32'h0A0B_0C0D, 2'b01, 1'b0, 0, 1'b0); // R7 address carry
    xfer(1'b0, 32'h6000_0000, 32'h1234_5678, 2'b00, 1'b0, 1, 1'b0); // R10 32-bit
    xfer(1'b0, 32'h7000_0010, 32'h9ABC_DEF0, 2'b01, 1'b0, 2, 1'b0); // R10 8-bit high
    xfer(1'b0, 32'h7000_0020, 32'h0F1E_2D3C, 2'b01, 1'b1, 0, 1'b0); // R10 8-bit low
    xfer(1'b0, 32'h8000_0030, 32'hA1B2_C3D4, 2'b10, 1'b1, 1, 1'b0); // R10 16-bit low
    xfer(1'b0, 32'h8000_0040, 32'h5566_7788, 2'b11, 1'b0, 0, 1'b0); // R10 16-bit high
    xfer(1'b1, 32'h9000_0050, 32'h0102_0304, 2'b01, 1'b0, 0, 1'b1); // R1 request while busy

    repeat (4) @(negedge clk);
    #1;
    chk(!busy && !bus_start, "R1 no extra transfer", {31'd0, busy}, 32'd0);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule